// File: doc/BRIEF.md
# Stream-Out / Command Mode Arbiter with Recovery Timeout

This block keeps track of which of three operating modes a serial memory device is in. After power-up the device streams its contents out on a dedicated stream clock. A master can take the device out of streaming by pulling the bus clock line low while the data line is released. The device then sits in a tentative transition mode, waiting for a start condition and an address byte. It also counts stream-clock edges and falls back to streaming when too many of them pass without bus activity.

Once an address byte carries the device code 1010, the block requests an acknowledge and latches command mode. Only a power-on reset leaves command mode. A stop condition in the middle of the address byte returns the device to streaming, and so does the timeout. On each return to streaming a one-cycle restart pulse tells the streaming logic to begin again at address 00h.

All three bus pins are asynchronous to the fast system clock. Each one passes through a synchronizer before its edges are detected.

Top module: `mode_switch_ctl`

## Requirements
- R1: After reset, `mode` is 2'b00 (stream-out), `ack_drive` is 0 and `stream_restart` is 0. The encodings are 2'b00 stream-out, 2'b01 transition and 2'b10 command.
- R2: In stream-out mode, a falling edge on `scl_in` while `sda_in` is high moves `mode` to 2'b01. A falling edge while `sda_in` is low leaves the mode at 2'b00, and so do `vclk_in` edges.
- R3: In transition mode, every falling edge of `scl_in` clears the count of `vclk_in` rising edges.
- R4: In transition mode, the 128th `vclk_in` rising edge counted since the last clear returns `mode` to 2'b00, and `stream_restart` is high for exactly one cycle. After 127 edges the mode is still 2'b01.
- R5: In transition mode, the address byte is sampled MSB first on `scl_in` rising edges after a start condition (`sda_in` falling while `scl_in` is high). `ack_drive` rises at the `scl_in` falling edge that ends the 8th bit, and only if the first four bits are 1,0,1,0. It falls at the next `scl_in` falling edge.
- R6: At the `scl_in` rising edge inside the acknowledge bit, `mode` becomes 2'b10. It then stays 2'b10 under any `vclk_in`, `scl_in` or `sda_in` activity until reset.
- R7: A stop condition (`sda_in` rising while `scl_in` is high) during the address byte, before the acknowledge bit, returns `mode` to 2'b00 and pulses `stream_restart` once.
- R8: With any other device code, `ack_drive` stays low and `mode` stays 2'b01, and the R4 timeout still applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the pin, asynchronous |
| vclk_in | input | 1 | Stream clock, asynchronous |
| mode | output | 2 | Current mode: 00 stream-out, 01 transition, 10 command |
| ack_drive | output | 1 | Request to pull the data line low for the acknowledge bit |
| stream_restart | output | 1 | One-cycle pulse on each re-entry into stream-out mode |

## Verification
The device-code check is swept over all sixteen upper-nibble values. This shows that exactly one code raises the acknowledge and latches command mode, while every other code leaves the block in transition. The timeout is tried with exactly 127 and 128 stream-clock edges, and again with a bus-clock fall in the middle of the count. The first run finds the exact limit and the second shows that the count is cleared rather than paused. Separate sequences cover an entry attempt with the data line low, a stop after four address bits, and stream-clock and stop activity after command mode is latched. Together they show which exits from transition are taken and that command mode has none.

// File: rtl/mode_switch_pkg.sv
package mode_switch_pkg;

    typedef enum logic [1:0] {
        MODE_STREAM = 2'b00,
        MODE_TRANS  = 2'b01,
        MODE_CMD    = 2'b10
    } dev_mode_e;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'b00,
        CAP_SHIFT = 2'b01,
        CAP_ACK   = 2'b10
    } cap_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda_lvl;
        logic vclk_rise;
    } bus_events_t;

    localparam int ADDR_BITS  = 8;
    localparam int CODE_BITS  = 4;
    localparam logic [CODE_BITS-1:0] DEV_CODE = 4'b1010;

    function automatic logic code_hit(input logic [ADDR_BITS-1:0] addr_byte,
                                      input logic [CODE_BITS-1:0] code);
        return addr_byte[ADDR_BITS-1 -: CODE_BITS] == code;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bus_event_detect.sv
module bus_event_detect
    import mode_switch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic        vclk_in,
    output bus_events_t ev
);
    localparam int NLINES = 3;
    localparam logic [NLINES-1:0] IDLE_LVL = 3'b011; // {vclk, sda, scl}

    logic [NLINES-1:0] raw, lvl, prv;
    logic [NLINES-1:0] rise, fall;

    assign raw = {vclk_in, sda_in, scl_in};

    pin_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prv <= IDLE_LVL;
        else     prv <= lvl;
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_edge
        assign rise[g] =  lvl[g] & ~prv[g];
        assign fall[g] = ~lvl[g] &  prv[g];
    end

    always_comb begin
        ev.scl_rise  = rise[0];
        ev.scl_fall  = fall[0];
        ev.sda_lvl   = lvl[1];
        ev.vclk_rise = rise[2];
        ev.start     = fall[1] & lvl[0] & prv[0];
        ev.stop      = rise[1] & lvl[0] & prv[0];
    end
endmodule

// File: rtl/addr_capture.sv
module addr_capture
    import mode_switch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        arm_ok,
    input  logic        keep,
    input  logic        drop,
    input  bus_events_t ev,
    output logic        ack_drive,
    output logic        grant_p,
    output logic        abort_p
);
    localparam int CNT_W = $clog2(ADDR_BITS + 1);

    cap_phase_e             phase;
    logic [CNT_W-1:0]       bit_cnt;
    logic [ADDR_BITS-1:0]   shreg;
    logic                   bits_done;

    assign bits_done = (bit_cnt == CNT_W'(ADDR_BITS));
    assign grant_p   = keep && (phase == CAP_ACK) && ev.scl_rise;
    assign abort_p   = keep && (phase == CAP_SHIFT) && ev.stop;

    always_ff @(posedge clk) begin
        if (rst || drop || !keep) begin
            phase     <= CAP_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            ack_drive <= 1'b0;
        end else if (ev.start && arm_ok) begin
            phase     <= CAP_SHIFT;
            bit_cnt   <= '0;
            shreg     <= '0;
            ack_drive <= 1'b0;
        end else begin
            unique case (phase)
                CAP_SHIFT: begin
                    if (ev.stop) begin
                        phase <= CAP_IDLE;
                    end else if (ev.scl_rise && !bits_done) begin
                        shreg   <= {shreg[ADDR_BITS-2:0], ev.sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (ev.scl_fall && bits_done) begin
                        if (code_hit(shreg, DEV_CODE)) begin
                            phase     <= CAP_ACK;
                            ack_drive <= 1'b1;
                        end else begin
                            phase <= CAP_IDLE;
                        end
                    end
                end
                CAP_ACK: begin
                    if (ev.scl_fall || ev.stop) begin
                        phase     <= CAP_IDLE;
                        ack_drive <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import mode_switch_pkg::*;
#(
    parameter int TIMEOUT_EDGES = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_events_t ev,
    input  logic        grant_p,
    input  logic        abort_p,
    output dev_mode_e   mode_q,
    output logic        drop_p,
    output logic        restart_q
);
    localparam int CW = $clog2(TIMEOUT_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_EDGES - 1);

    logic [CW-1:0] vcnt;
    logic          timeout_hit;

    assign timeout_hit = (mode_q == MODE_TRANS) && !grant_p && !ev.scl_fall &&
                         ev.vclk_rise && (vcnt == LAST);
    assign drop_p      = (mode_q == MODE_TRANS) && !grant_p && (abort_p || timeout_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_STREAM;
            vcnt      <= '0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            unique case (mode_q)
                MODE_STREAM: begin
                    vcnt <= '0;
                    if (ev.scl_fall && ev.sda_lvl) mode_q <= MODE_TRANS;
                end
                MODE_TRANS: begin
                    if (grant_p) begin
                        mode_q <= MODE_CMD;
                        vcnt   <= '0;
                    end else if (drop_p) begin
                        mode_q    <= MODE_STREAM;
                        vcnt      <= '0;
                        restart_q <= 1'b1;
                    end else if (ev.scl_fall) begin
                        vcnt <= '0;
                    end else if (ev.vclk_rise) begin
                        vcnt <= vcnt + 1'b1;
                    end
                end
                default: begin
                    mode_q <= MODE_CMD;
                    vcnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mode_switch_ctl.sv
module mode_switch_ctl
    import mode_switch_pkg::*;
#(
    parameter int TIMEOUT_EDGES = 128,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       vclk_in,
    output logic [1:0] mode,
    output logic       ack_drive,
    output logic       stream_restart
);
    bus_events_t ev;
    dev_mode_e   mode_q;
    logic        grant_p, abort_p, drop_p;

    bus_event_detect #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .vclk_in (vclk_in),
        .ev      (ev)
    );

    addr_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .arm_ok    (mode_q == MODE_TRANS),
        .keep      (mode_q != MODE_STREAM),
        .drop      (drop_p),
        .ev        (ev),
        .ack_drive (ack_drive),
        .grant_p   (grant_p),
        .abort_p   (abort_p)
    );

    mode_fsm #(.TIMEOUT_EDGES(TIMEOUT_EDGES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .grant_p   (grant_p),
        .abort_p   (abort_p),
        .mode_q    (mode_q),
        .drop_p    (drop_p),
        .restart_q (stream_restart)
    );

    assign mode = mode_q;
endmodule

// File: rtl/mode_switch_checker.sv
module mode_switch_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       ack_drive,
    input logic       stream_restart
);
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11); // R1
    AST_NO_DIRECT_CMD: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b00 |=> mode != 2'b10); // R2
    AST_RESTART_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        stream_restart |-> (mode == 2'b00 && $past(mode) == 2'b01)); // R4
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stream_restart |=> !stream_restart); // R4
    AST_ACK_NOT_STREAM: assert property (@(posedge clk) disable iff (rst)
        ack_drive |-> mode != 2'b00); // R5
    AST_CMD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && $past(mode) == 2'b01) |-> $past(ack_drive)); // R6
    AST_CMD_STICKY: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b10 |=> mode == 2'b10); // R6
endmodule

bind mode_switch_ctl mode_switch_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .mode           (mode),
    .ack_drive      (ack_drive),
    .stream_restart (stream_restart)
);

// File: tb/sim_mode_switch_ctl.sv
`timescale 1ns/1ps
module sim_mode_switch_ctl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, sda = 1'b1, vclk = 1'b0;
    logic [1:0] mode;
    logic ack, restart;
    int checks = 0, fails = 0, rcount = 0;
    bit done = 0;

    always #4 clk = ~clk; // 125 MHz

    mode_switch_ctl u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .vclk_in(vclk),
        .mode(mode), .ack_drive(ack), .stream_restart(restart)
    );

    always @(negedge clk) if (!rst && restart) rcount++;

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic power_on();
        rst = 1'b1; scl = 1'b1; sda = 1'b1; vclk = 1'b0;
        wait_n(6);
        rst = 1'b0;
        wait_n(4);
    endtask

    task automatic set_scl(logic v); scl = v; wait_n(5); endtask
    task automatic set_sda(logic v); sda = v; wait_n(5); endtask

    task automatic vclk_edges(int n);
        for (int i = 0; i < n; i++) begin
            vclk = 1'b1; wait_n(4);
            vclk = 1'b0; wait_n(4);
        end
    endtask

    task automatic enter_trans();
        set_scl(1'b0);
        set_scl(1'b1);
    endtask

    // start, then eight address bits MSB first; ends with SCL low after 8th bit
    task automatic send_addr(logic [7:0] a);
        set_sda(1'b0);
        set_scl(1'b0);
        for (int i = 7; i >= 0; i--) begin
            set_sda(a[i]);
            set_scl(1'b1);
            set_scl(1'b0);
        end
        set_sda(1'b1);
    endtask

    initial begin
        int r0;
        power_on();
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 ack", ack, 0);
        check("R1 restart", restart, 0);

        // R2 vclk edges in stream mode do nothing
        vclk_edges(200);
        check("R2 vclk in stream", mode, 0);
        check("R2 no restart", rcount, 0);
        // R2 SCL fall with SDA low keeps stream mode
        set_sda(1'b0); set_scl(1'b0);
        check("R2 sda low fall", mode, 0);
        set_scl(1'b1); set_sda(1'b1);
        check("R2 still stream", mode, 0);
        // R2 valid entry
        set_scl(1'b0);
        check("R2 enter trans", mode, 1);
        set_scl(1'b1);

        // R4 timeout at exactly 128
        r0 = rcount;
        vclk_edges(127);
        check("R4 127 edges", mode, 1);
        vclk_edges(1);
        check("R4 128 edges", mode, 0);
        check("R4 one restart", rcount - r0, 1);

        // R3 SCL fall clears count
        power_on();
        enter_trans();
        vclk_edges(100);
        set_scl(1'b0); set_scl(1'b1);
        vclk_edges(100);
        check("R3 cleared count", mode, 1);
        vclk_edges(27);
        check("R3 127 after clear", mode, 1);
        vclk_edges(1);
        check("R3 128 after clear", mode, 0);

        // R5 R6 matching code
        power_on();
        enter_trans();
        send_addr(8'b1010_0001);
        check("R5 ack on", ack, 1);
        check("R5 still trans", mode, 1);
        set_scl(1'b1);
        check("R6 cmd latched", mode, 2);
        check("R5 ack held in 9th", ack, 1);
        set_scl(1'b0);
        check("R5 ack off", ack, 0);
        r0 = rcount;
        vclk_edges(300);
        check("R6 vclk no effect", mode, 2);
        set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
        check("R6 stop no effect", mode, 2);
        set_scl(1'b0); set_scl(1'b1);
        vclk_edges(130);
        check("R6 still cmd", mode, 2);
        check("R6 no restart", rcount - r0, 0);
        power_on();
        check("R6 reset returns stream", mode, 0);

        // R7 stop during address byte
        power_on();
        enter_trans();
        r0 = rcount;
        set_sda(1'b0); set_scl(1'b0);
        for (int i = 0; i < 4; i++) begin
            set_sda(i[0]); set_scl(1'b1); set_scl(1'b0);
        end
        check("R7 mid byte trans", mode, 1);
        set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
        check("R7 stop to stream", mode, 0);
        check("R7 restart pulse", rcount - r0, 1);
        check("R7 no ack", ack, 0);

        // R5 R8 sweep over all device codes
        for (int c = 0; c < 16; c++) begin
            logic hit;
            hit = (c == 10);
            power_on();
            enter_trans();
            send_addr({c[3:0], 4'b0110});
            check(hit ? "R5 ack match" : "R8 ack mismatch", ack, hit ? 1 : 0);
            set_scl(1'b1);
            check(hit ? "R6 mode match" : "R8 mode mismatch", mode, hit ? 2 : 1);
            set_scl(1'b0);
            check(hit ? "R5 ack released" : "R8 ack stays low", ack, 0);
        end

        // R8 timeout after mismatch
        power_on();
        enter_trans();
        send_addr(8'b1011_0000);
        set_scl(1'b1); set_scl(1'b0);
        r0 = rcount;
        vclk_edges(127);
        check("R8 127 after mismatch", mode, 1);
        vclk_edges(1);
        check("R8 timeout after mismatch", mode, 0);
        check("R8 restart", rcount - r0, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule